// File: doc/BRIEF.md
# Fused Sum-Recoded Booth Multiplier

This block returns the signed product (A + B) × X for three two's-complement operands. It never forms A + B with a carry-propagate adder. Instead, each pair of bit positions from A and B is recoded straight into one radix-4 signed digit. The recoder is built from two kinds of cell:

- a signed half-adder cell on the odd bit of each pair;
- a full-adder cell on the even bit of each pair.

A small second transfer keeps every digit inside the set {-2, -1, 0, +1, +2}. No carry crosses more than two digit positions. Each digit picks zero, X or 2X as a partial product, and negates it by inversion plus a correction bit. The rows are then summed to form the result.

The block takes one operand triple per clock, marked by a valid strobe. It returns the result two clock edges later with its own valid strobe. The operand width `W` must be even. The result is `2W+1` bits wide, which holds every product exactly.

Top module: `sum_booth_fma`

## Requirements
- R1: When `out_valid` is high, `out_p` equals the exact signed product (A + B) × X of the operands sampled two rising edges earlier. The product is 2W+1 bits wide in two's complement.
- R2: Operands are sampled on every rising edge where `in_valid` is high. `out_valid` is high exactly two rising edges later, one result per accepted triple, including back-to-back triples.
- R3: While `rst_n` is low, `out_valid` is 0 and `out_p` is 0.
- R4: In any cycle without a new result, `out_p` keeps its last value. Operand values presented while `in_valid` is low have no effect on any later output.
- R5: Each recoded digit is carried as three bits: negative, magnitude-one and magnitude-two. Magnitude-one and magnitude-two are never both set, and the negative bit is set only when one of them is set.
- R6: The recoder emits W/2 + 1 digits. Their radix-4 weighted sum equals A + B exactly.
- R7: The extreme operand corners give exact results. These include A = B = X = most negative, which gives +2^(2W-1), and A = B = most positive with X = most negative.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand triple present this cycle |
| in_a | input | W | First addend, signed |
| in_b | input | W | Second addend, signed |
| in_x | input | W | Multiplicand, signed |
| out_valid | output | 1 | Result present this cycle |
| out_p | output | 2W+1 | Signed product (A + B) × X |

## Verification
The following are checked by properties on every cycle:
- the recoded digits stay legal, and their weighted sum equals A + B for every accepted triple;
- each result matches the exact product two edges after its operands;
- the valid strobe follows the input strobe with a two-edge delay;
- the output holds steady between results.

The reset values, and the fact that operands present while `in_valid` is low are ignored, show only in the bench's scenarios. So do the operand corners at the most negative and most positive values, and the mix of back-to-back and gapped traffic.

// File: rtl/sum_booth_fma.sv
module sum_booth_fma #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  input  logic [W-1:0]   in_x,
  output logic           out_valid,
  output logic [2*W:0]   out_p
);
  localparam int EW   = W + 2;
  localparam int NDIG = EW / 2;
  localparam int RW   = W + 1;
  localparam int PW   = 2 * W + 1;

  logic [EW-1:0] ea, eb;
  assign ea = {{2{in_a[W-1]}}, in_a};
  assign eb = {{2{in_b[W-1]}}, in_b};

  logic [NDIG-1:0] gout, gin, tout, tin;
  logic [NDIG-1:0] dneg, done, dtwo;
  logic [NDIG-1:0][RW-1:0] rows;
  logic [RW-1:0] xs, x2;

  assign xs  = {in_x[W-1], in_x};
  assign x2  = {in_x, 1'b0};
  assign gin = {gout[NDIG-2:0], 1'b0};
  assign tin = {tout[NDIG-2:0], 1'b0};

  for (genvar j = 0; j < NDIG; j++) begin : g_dig
    logic se, ce, ho;
    logic [3:0] dv;
    assign ho      = ea[2*j+1] ^ eb[2*j+1];
    assign gout[j] = ea[2*j+1] | eb[2*j+1];
    assign se      = gin[j] ^ ea[2*j] ^ eb[2*j];
    assign ce      = (gin[j] & ea[2*j]) | (gin[j] & eb[2*j]) | (ea[2*j] & eb[2*j]);
    assign tout[j] = ce & ~ho;
    assign dv      = {3'b000, se} + {2'b00, ce, 1'b0} - {2'b00, ho, 1'b0}
                   - {1'b0, tout[j], 2'b00} + {3'b000, tin[j]};
    assign dneg[j] = dv[3];
    assign done[j] = (dv == 4'd1) || (dv == 4'hF);
    assign dtwo[j] = (dv == 4'd2) || (dv == 4'hE);
    assign rows[j] = {RW{dneg[j]}} ^ (done[j] ? xs : (dtwo[j] ? x2 : '0));
  end

  logic                    v1;
  logic [NDIG-1:0][RW-1:0] rows_q;
  logic [NDIG-1:0]         neg_q;
  logic [PW-1:0]           acc;

  always_comb begin
    acc = '0;
    for (int j = 0; j < NDIG; j++) begin
      acc = acc + ((PW'($signed(rows_q[j])) + PW'(neg_q[j])) << (2 * j));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1        <= 1'b0;
      rows_q    <= '0;
      neg_q     <= '0;
      out_valid <= 1'b0;
      out_p     <= '0;
    end else begin
      v1        <= in_valid;
      out_valid <= v1;
      if (in_valid) begin
        rows_q <= rows;
        neg_q  <= dneg;
      end
      if (v1) out_p <= acc;
    end
  end
endmodule

module sum_booth_fma_chk #(
  parameter int W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [W-1:0]         in_a,
  input logic [W-1:0]         in_b,
  input logic [W-1:0]         in_x,
  input logic                 out_valid,
  input logic [2*W:0]         out_p,
  input logic [W/2:0]         dneg,
  input logic [W/2:0]         done,
  input logic [W/2:0]         dtwo
);
  localparam int NDIG = W / 2 + 1;
  localparam int PW   = 2 * W + 1;
  localparam int SW   = W + 4;

  logic [PW-1:0] refp;
  logic [SW-1:0] dsum, asum;

  always_comb begin
    refp = (PW'($signed(in_a)) + PW'($signed(in_b))) * PW'($signed(in_x));
    asum = SW'($signed(in_a)) + SW'($signed(in_b));
    dsum = '0;
    for (int j = 0; j < NDIG; j++) begin
      if (dneg[j]) dsum = dsum - (SW'({done[j] ? 2'b01 : (dtwo[j] ? 2'b10 : 2'b00)}) << (2 * j));
      else         dsum = dsum + (SW'({done[j] ? 2'b01 : (dtwo[j] ? 2'b10 : 2'b00)}) << (2 * j));
    end
  end

  a_r1_exact_product: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_p == $past(refp, 2));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);

  a_r4_output_held: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_p));

  a_r6_digit_sum: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> dsum == asum);

  for (genvar j = 0; j < NDIG; j++) begin : g_dchk
    a_r5_magnitude_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> $onehot0({done[j], dtwo[j]}));
    a_r5_sign_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dneg[j]) |-> (done[j] || dtwo[j]));
  end
endmodule

bind sum_booth_fma sum_booth_fma_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .in_a(in_a), .in_b(in_b), .in_x(in_x),
  .out_valid(out_valid), .out_p(out_p),
  .dneg(dneg), .done(done), .dtwo(dtwo)
);

// File: tb/tb_sum_booth_fma.sv
module tb_sum_booth_fma;
  localparam int W  = 8;
  localparam int PW = 2 * W + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [W-1:0]  in_a, in_b, in_x;
  logic          out_valid;
  logic [PW-1:0] out_p;

  always #5 clk = ~clk;

  sum_booth_fma #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_x(in_x),
    .out_valid(out_valid), .out_p(out_p)
  );

  int checks = 0;
  int fails  = 0;
  bit timeout = 0;

  logic          pv0 = 1'b0, pv1 = 1'b0;
  logic [PW-1:0] pe0 = '0, pe1 = '0, held = '0;

  function automatic logic [PW-1:0] ref_prod(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] x);
    logic signed [W:0]    s;
    logic signed [PW-1:0] se, xe;
    s  = $signed({a[W-1], a}) + $signed({b[W-1], b});
    se = {{(PW-W-1){s[W]}}, s};
    xe = {{(PW-W){x[W-1]}}, x};
    return se * xe;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] x);
    @(negedge clk);
    check(out_valid == pv1, "R2 valid timing", longint'(out_valid), longint'(pv1));
    if (pv1) begin
      check(out_p == pe1, "R1 product (digits R5 R6)",
            longint'($signed(out_p)), longint'($signed(pe1)));
      held = pe1;
    end else begin
      check(out_p == held, "R4 output held, idle operands ignored",
            longint'($signed(out_p)), longint'($signed(held)));
    end
    pv1 = pv0; pe1 = pe0;
    pv0 = v;   pe0 = ref_prod(a, b, x);
    in_valid = v; in_a = a; in_b = b; in_x = x;
  endtask

  task automatic run();
    logic [W-1:0] mn, mx;
    mn = {1'b1, {(W-1){1'b0}}};
    mx = {1'b0, {(W-1){1'b1}}};
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0; in_x = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R3 reset valid", longint'(out_valid), 0);
    check(out_p == '0, "R3 reset product", longint'($signed(out_p)), 0);
    rst_n = 1'b1;
    // R7 corners, back to back
    step(1'b1, mn, mn, mn);
    step(1'b1, mx, mx, mn);
    step(1'b1, mx, mx, mx);
    step(1'b1, mn, mx, mn);
    step(1'b1, '0, '0, mn);
    step(1'b1, '1, '1, '1);
    step(1'b1, mn, '0, mx);
    step(1'b0, mx, mx, mx);
    step(1'b0, mn, mn, mn);
    step(1'b0, '1, mn, mx);
    step(1'b1, 8'd1, '1, mn);
    step(1'b0, '0, '0, '0);
    step(1'b0, mx, '0, mx);
    step(1'b0, '0, '0, '0);
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 10) < 7, W'($urandom), W'($urandom), W'($urandom));
    end
    for (int i = 0; i < 4; i++) step(1'b0, W'($urandom), W'($urandom), W'($urandom));
  endtask

  initial begin
    fork
      run();
      begin
        repeat (200000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule